// File: doc/BRIEF.md
# Four-Rail Power Sequencing Controller

This block brings up four dependent supply rails in a fixed order and takes them down in the reverse order. It watches two flags from external comparators. One reports that a monitored supply is above its lower limit. The other reports that the supply has crossed its upper limit. It also watches a sequence-go request. When the supply is compliant and the request is high, a programmable start delay runs. The first enable then asserts, and each later enable follows after its own programmable gap. Dropping the request runs the same start delay again and releases the enables last-to-first, using the same gaps.

A voltage excursion at any moment, including during the start delay, clears all four enables in a single cycle. It also restarts the start qualification. All timing counts pulses of a one-cycle tick input, so the real-time scale is set by whatever divider produces that tick. A separate compliance flag reports loss of the voltage window at once. It releases only after the window has been held for a qualification period.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: The state output uses these codes: 0 idle, 1 start delay, 2 ramp up, 3 all on, 4 stop delay, 5 ramp down. The block leaves idle only when the synchronised under-voltage-ok flag is 1, the synchronised over-voltage flag is 0, and the synchronised sequence-go input is 1. A missing condition keeps all enables inactive and the state at 0.
- R2: The three asynchronous inputs pass through two flops each. A start needs max(start_dly_i,1) ticks. With the tick high every cycle, enable A (en_o bit 0) changes 4 + start_dly_i cycles after the inputs that permit the start. A voltage fault, or sequence-go falling during the start delay, returns the block to idle. The next start then runs the full delay from zero.
- R3: Enables turn on in the order A, B, C, D (bits 0 to 3). The gaps A to B, B to C and C to D use gap_ab_i, gap_bc_i and gap_cd_i, and the counter restarts at each stage. With the tick high every cycle, a gap of g gives max(g,1)+1 cycles between output changes. At most one enable changes per cycle, except for a fault shutdown.
- R4: A voltage fault forces all four enables inactive on the same clock edge, 3 cycles after the input change. This holds in any state, and it overrides a stage advance that falls on that same edge.
- R5: When sequence-go falls while all rails are on, the start delay runs again and D turns off. C follows gap_cd_i ticks later, B follows gap_bc_i ticks later, and A follows gap_ab_i ticks later. D turns off 4 + start_dly_i cycles after the input falls.
- R6: While por_i is high, all enables are inactive, the block is held in idle and the fault flag is set.
- R7: The parameter ACT_LOW = 0 gives active-high enables. ACT_LOW = 1 gives active-low enables, each being the bitwise complement of the active-high value.
- R8: fault_o is 1 after reset. It rises one cycle after the synchronised window is lost. It falls only after FLT_CYC consecutive compliant synchronised cycles, which is FLT_CYC cycles after por_i falls with compliance already present.
- R9: A gap or start delay programmed to 0 counts as 1 tick, so two enables never change on the same edge.
- R10: If sequence-go returns high during the turn-off, the turn-off completes. A new turn-on then starts, and A asserts start_dly_i + 2 cycles after A was released.
- R11: If sequence-go falls during the turn-on, the turn-on completes. The turn-off then starts, and D is released start_dly_i + 2 cycles after D asserted.
- R12: The delay counter advances only in cycles where tick_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on reset hold, active high |
| tick_i | input | 1 | One-cycle timing pulse |
| uv_ok_i | input | 1 | Supply above lower limit (asynchronous) |
| ov_hit_i | input | 1 | Supply above upper limit (asynchronous) |
| seq_go_i | input | 1 | Sequence request (asynchronous) |
| start_dly_i | input | 16 | Start and stop delay in ticks |
| gap_ab_i | input | 16 | Gap between A and B in ticks |
| gap_bc_i | input | 16 | Gap between B and C in ticks |
| gap_cd_i | input | 16 | Gap between C and D in ticks |
| en_o | output | 4 | Rail enables, bit 0 = A |
| fault_o | output | 1 | Voltage window not qualified |
| state_o | output | 3 | Sequencer state code |

## Verification
A fault shutdown and a stage advance can land on the same clock edge. The bench provokes this by raising the over-voltage flag exactly three cycles before the edge on which B would assert. That edge is computed from the start delay and the A-to-B gap. The scoreboard then expects the next output change to clear all four enables, one A-to-B gap after A rose. It expects fault_o set in that same sample and no B pattern at any point.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;
  localparam int unsigned DLY_W = 16;
  localparam int unsigned RAILS = 4;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_START   = 3'd1,
    ST_RAMP_UP = 3'd2,
    ST_ON      = 3'd3,
    ST_STOP    = 3'd4,
    ST_RAMP_DN = 3'd5
  } seq_state_e;

  // a programmed zero still waits one tick
  function automatic logic [DLY_W-1:0] eff_ticks(input logic [DLY_W-1:0] d);
    return (d == '0) ? DLY_W'(1) : d;
  endfunction

  // 0 = start/stop delay, 1 = A-B gap, 2 = B-C gap, 3 = C-D gap
  function automatic logic [1:0] delay_sel(input seq_state_e st, input logic [1:0] stg);
    case (st)
      ST_RAMP_UP: return stg;
      ST_RAMP_DN: return stg + 2'd1;
      default:    return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/pwr_seq_sync.sv
`timescale 1ns/1ps
module pwr_seq_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pwr_seq_qual.sv
`timescale 1ns/1ps
module pwr_seq_qual #(
  parameter int unsigned FLT_CYC = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_i,
  input  logic ok_i,
  output logic fault_o
);
  localparam int unsigned QW = $clog2(FLT_CYC + 1);
  localparam logic [QW-1:0] QLAST = QW'(FLT_CYC - 1);

  logic [QW-1:0] qcnt_q;
  logic          fault_q;
  logic          qual_done;

  assign qual_done = (qcnt_q >= QLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt_q  <= '0;
      fault_q <= 1'b1;
    end else if (por_i || !ok_i) begin
      qcnt_q  <= '0;
      fault_q <= 1'b1;
    end else begin
      if (!qual_done) qcnt_q <= qcnt_q + 1'b1;
      fault_q <= !qual_done;
    end
  end

  assign fault_o = fault_q;

  // R8: loss of window is reported on the next edge
  a_r8_fault_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_i |=> fault_q);
  // R8: release only follows a compliant cycle
  a_r8_release_ok: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> $past(ok_i) && !$past(por_i));
endmodule

// File: rtl/pwr_seq_timer.sv
`timescale 1ns/1ps
module pwr_seq_timer
  import pwr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] limit_i,
  output logic             expired_o
);
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] lim_eff;

  assign lim_eff   = eff_ticks(limit_i);
  assign expired_o = (cnt_q >= lim_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (tick_i && !expired_o)  cnt_q <= cnt_q + 1'b1;
  end

  // R9: a cleared window never expires on the following cycle
  a_r9_min_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !expired_o);
  // R12: without a tick the count holds
  a_r12_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pwr_seq_fsm.sv
`timescale 1ns/1ps
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_i,
  input  logic             ok_i,
  input  logic             go_i,
  input  logic             expired_i,
  output logic             tmr_clr_o,
  output logic [1:0]       sel_o,
  output logic [RAILS-1:0] en_o,
  output seq_state_e       state_o
);
  seq_state_e       st_q, st_d;
  logic [1:0]       stg_q, stg_d;
  logic [RAILS-1:0] en_q, en_d;
  logic             clr;

  always_comb begin
    st_d  = st_q;
    stg_d = stg_q;
    en_d  = en_q;
    clr   = 1'b0;
    if (!ok_i) begin
      st_d  = ST_IDLE;
      stg_d = 2'd0;
      en_d  = '0;
      clr   = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: if (go_i) begin
          st_d = ST_START;
          clr  = 1'b1;
        end
        ST_START: if (!go_i) begin
          st_d = ST_IDLE;
          clr  = 1'b1;
        end else if (expired_i) begin
          en_d[0] = 1'b1;
          stg_d   = 2'd1;
          st_d    = ST_RAMP_UP;
          clr     = 1'b1;
        end
        ST_RAMP_UP: if (expired_i) begin
          en_d[stg_q] = 1'b1;
          clr         = 1'b1;
          if (stg_q == 2'd3) st_d = ST_ON;
          else               stg_d = stg_q + 2'd1;
        end
        ST_ON: if (!go_i) begin
          st_d = ST_STOP;
          clr  = 1'b1;
        end
        ST_STOP: if (expired_i) begin
          en_d[3] = 1'b0;
          stg_d   = 2'd2;
          st_d    = ST_RAMP_DN;
          clr     = 1'b1;
        end
        ST_RAMP_DN: if (expired_i) begin
          en_d[stg_q] = 1'b0;
          clr         = 1'b1;
          if (stg_q == 2'd0) st_d = ST_IDLE;
          else               stg_d = stg_q - 2'd1;
        end
        default: begin
          st_d = ST_IDLE;
          en_d = '0;
          clr  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      stg_q <= 2'd0;
      en_q  <= '0;
    end else if (por_i) begin
      st_q  <= ST_IDLE;
      stg_q <= 2'd0;
      en_q  <= '0;
    end else begin
      st_q  <= st_d;
      stg_q <= stg_d;
      en_q  <= en_d;
    end
  end

  assign tmr_clr_o = clr | por_i;
  assign sel_o     = delay_sel(st_q, stg_q);
  assign en_o      = en_q;
  assign state_o   = st_q;

  // R3: enables always form a prefix A, AB, ABC, ABCD
  a_r3_prefix_order: assert property (@(posedge clk) disable iff (!rst_n)
    en_q inside {4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111});
  // R3 and R9: one rail per edge, except the collective drop
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q != $past(en_q)) |-> ($countones(en_q ^ $past(en_q)) == 1 || en_q == '0));
  // R2: a fault during the start delay returns to idle
  a_r2_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && !ok_i) |=> (st_q == ST_IDLE && en_q == '0));
endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter bit          ACT_LOW = 1'b0,
  parameter int unsigned FLT_CYC = 3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_i,
  input  logic             tick_i,
  input  logic             uv_ok_i,
  input  logic             ov_hit_i,
  input  logic             seq_go_i,
  input  logic [DLY_W-1:0] start_dly_i,
  input  logic [DLY_W-1:0] gap_ab_i,
  input  logic [DLY_W-1:0] gap_bc_i,
  input  logic [DLY_W-1:0] gap_cd_i,
  output logic [RAILS-1:0] en_o,
  output logic             fault_o,
  output logic [2:0]       state_o
);
  logic [2:0]       raw_in, sync_in;
  logic             uv_s, ov_s, go_s, ok_s;
  logic             tmr_clr, tmr_exp;
  logic [1:0]       sel;
  logic [DLY_W-1:0] limit;
  logic [RAILS-1:0] fsm_en, en_act;
  seq_state_e       fsm_st;

  assign raw_in = {seq_go_i, ov_hit_i, uv_ok_i};

  pwr_seq_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_in)
  );

  assign uv_s = sync_in[0];
  assign ov_s = sync_in[1];
  assign go_s = sync_in[2];
  assign ok_s = uv_s & ~ov_s;

  always_comb begin
    case (sel)
      2'd0:    limit = start_dly_i;
      2'd1:    limit = gap_ab_i;
      2'd2:    limit = gap_bc_i;
      default: limit = gap_cd_i;
    endcase
  end

  pwr_seq_timer u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .tick_i(tick_i),
    .limit_i(limit), .expired_o(tmr_exp)
  );

  pwr_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .ok_i(ok_s), .go_i(go_s),
    .expired_i(tmr_exp), .tmr_clr_o(tmr_clr), .sel_o(sel),
    .en_o(fsm_en), .state_o(fsm_st)
  );

  pwr_seq_qual #(.FLT_CYC(FLT_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .ok_i(ok_s), .fault_o(fault_o)
  );

  // bias hold gates the enables without waiting for a clock edge
  assign en_act  = fsm_en & ~{RAILS{por_i}};
  assign state_o = fsm_st;

  generate
    if (ACT_LOW) begin : g_pol_low
      assign en_o = ~en_act;
    end else begin : g_pol_high
      assign en_o = en_act;
    end
  endgenerate

  // R4: window loss clears every rail and raises the flag on one edge
  a_r4_all_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_s |=> (en_act == '0 && fault_o));
  // R6: bias hold returns the sequencer to idle
  a_r6_por_idle: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (fsm_en == '0 && fsm_st == ST_IDLE && fault_o));
  // R1: leaving idle needs compliance and a request
  a_r1_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_st == ST_IDLE && !(ok_s && go_s)) |=> fsm_st == ST_IDLE);
endmodule

// File: tb/pwr_seq_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb_top;
  localparam int N   = 6;
  localparam int GAB = 3;
  localparam int GBC = 0;
  localparam int GCD = 5;
  localparam int FLT = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, por, tick, uv_ok, ov_hit, go;
  logic [15:0] sd, gab, gbc, gcd;
  logic [3:0]  en_o, en_n;
  logic        fault_o, fault_n;
  logic [2:0]  state_o, state_n;

  pwr_seq_ctrl #(.ACT_LOW(1'b0), .FLT_CYC(FLT)) dut_i (
    .clk(clk), .rst_n(rst_n), .por_i(por), .tick_i(tick), .uv_ok_i(uv_ok),
    .ov_hit_i(ov_hit), .seq_go_i(go), .start_dly_i(sd), .gap_ab_i(gab),
    .gap_bc_i(gbc), .gap_cd_i(gcd), .en_o(en_o), .fault_o(fault_o), .state_o(state_o)
  );

  pwr_seq_ctrl #(.ACT_LOW(1'b1), .FLT_CYC(FLT)) dut_n (
    .clk(clk), .rst_n(rst_n), .por_i(por), .tick_i(tick), .uv_ok_i(uv_ok),
    .ov_hit_i(ov_hit), .seq_go_i(go), .start_dly_i(sd), .gap_ab_i(gab),
    .gap_bc_i(gbc), .gap_cd_i(gcd), .en_o(en_n), .fault_o(fault_n), .state_o(state_n)
  );

  typedef struct {
    logic [3:0] mask;
    int         gap;
    int         tol;
    string      req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  int   ref_cyc = 0;
  int   tick_div = 1;
  int   tick_ph  = 0;
  logic [3:0] last_en = 4'b0000;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tick_div <= 1) tick = 1'b1;
    else begin
      tick    = (tick_ph == 0);
      tick_ph = (tick_ph + 1) % tick_div;
    end
  end

  function automatic int eff(input int g);
    return (g == 0) ? 1 : g;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [3:0] m, input int g, input int tol, input string r);
    exp_t e;
    e.mask = m; e.gap = g; e.tol = tol; e.req = r;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mark();
    ref_cyc = cyc;
  endtask

  task automatic drain(input string r);
    int k;
    k = 0;
    while (q.size() != 0 && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk(q.size() == 0, r, "pending expected changes", q.size(), 0);
  endtask

  task automatic push_on(input string r);
    push(4'b0011, eff(GAB) + 1, 0, r);
    push(4'b0111, eff(GBC) + 1, 0, "R9");
    push(4'b1111, eff(GCD) + 1, 0, r);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor: pops the scoreboard on every enable change
  initial begin
    forever begin : mon_blk
      int   gap;
      exp_t e;
      @(posedge clk);
      #2;
      if (en_o !== last_en) begin
        gap = cyc - ref_cyc;
        if (q.size() == 0) begin
          chk(1'b0, "R3", "unexpected enable change", int'(en_o), int'(last_en));
        end else begin
          e = q.pop_front();
          chk(en_o == e.mask, e.req, "enable pattern", int'(en_o), int'(e.mask));
          chk(gap >= e.gap && gap <= e.gap + e.tol, e.req, "gap cycles", gap, e.gap);
        end
        chk(en_n == ~en_o, "R7", "active-low copy", int'(en_n), int'(4'(~en_o)));
        ref_cyc = cyc;
        last_en = en_o;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; por = 1'b1; uv_ok = 1'b0; ov_hit = 1'b0; go = 1'b0;
    sd = 16'(N); gab = 16'(GAB); gbc = 16'(GBC); gcd = 16'(GCD);
    step(3);
    chk(en_o == 4'b0000, "R6", "reset enables", int'(en_o), 0);
    chk(en_n == 4'b1111, "R7", "reset active-low enables", int'(en_n), 15);
    chk(fault_o == 1'b1, "R8", "reset fault flag", int'(fault_o), 1);
    chk(state_o == 3'd0, "R1", "reset state", int'(state_o), 0);

    // bias hold with start conditions present
    rst_n = 1'b1; uv_ok = 1'b1; go = 1'b1;
    step(10);
    chk(en_o == 4'b0000, "R6", "enables during hold", int'(en_o), 0);
    chk(state_o == 3'd0, "R6", "state during hold", int'(state_o), 0);

    // release hold: turn-on and fault qualification
    push(4'b0001, N + 2, 0, "R2");
    push_on("R3");
    por = 1'b0; mark();
    step(FLT - 1);
    chk(fault_o == 1'b1, "R8", "flag before qualification", int'(fault_o), 1);
    step(1);
    chk(fault_o == 1'b0, "R8", "flag after qualification", int'(fault_o), 0);
    drain("R3");
    chk(state_o == 3'd3, "R3", "all-on state", int'(state_o), 3);

    // reverse turn-off
    push(4'b0111, N + 4, 0, "R5");
    push(4'b0011, eff(GCD) + 1, 0, "R5");
    push(4'b0001, eff(GBC) + 1, 0, "R5");
    push(4'b0000, eff(GAB) + 1, 0, "R5");
    go = 1'b0; mark();
    drain("R5");
    chk(state_o == 3'd0, "R5", "idle after turn-off", int'(state_o), 0);

    // request withdrawn inside the start delay
    go = 1'b1; step(4); go = 1'b0;
    step(N + 10);
    chk(en_o == 4'b0000, "R2", "no enable after withdrawn request", int'(en_o), 0);
    chk(state_o == 3'd0, "R2", "idle after withdrawn request", int'(state_o), 0);

    // fault aborts the start delay; restart runs the full delay
    go = 1'b1; mark();
    step(N);
    ov_hit = 1'b1;
    step(5);
    chk(en_o == 4'b0000, "R2", "enables after abort", int'(en_o), 0);
    chk(state_o == 3'd0, "R2", "idle after abort", int'(state_o), 0);
    chk(fault_o == 1'b1, "R8", "flag after abort", int'(fault_o), 1);
    push(4'b0001, N + 4, 0, "R2");
    push_on("R3");
    ov_hit = 1'b0; mark();
    drain("R2");

    // fault while all on: simultaneous drop
    push(4'b0000, 3, 0, "R4");
    ov_hit = 1'b1; mark();
    step(3);
    chk(en_o == 4'b0000, "R4", "all rails dropped", int'(en_o), 0);
    chk(fault_o == 1'b1, "R4", "flag in drop cycle", int'(fault_o), 1);
    drain("R4");
    go = 1'b0; step(2); ov_hit = 1'b0;
    step(FLT + 5);
    chk(fault_o == 1'b0, "R8", "flag released again", int'(fault_o), 0);

    // fault lands on the edge where B would assert
    push(4'b0001, N + 4, 0, "R2");
    push(4'b0000, eff(GAB) + 1, 0, "R4");
    go = 1'b1; mark();
    step(N + eff(GAB) + 2);
    ov_hit = 1'b1;
    drain("R4");
    chk(fault_o == 1'b1, "R4", "flag after collision", int'(fault_o), 1);
    chk(state_o == 3'd0, "R4", "idle after collision", int'(state_o), 0);
    go = 1'b0; step(2); ov_hit = 1'b0;
    step(FLT + 5);

    // request falls during turn-on
    push(4'b0001, N + 4, 0, "R11");
    push_on("R11");
    push(4'b0111, N + 2, 0, "R11");
    push(4'b0011, eff(GCD) + 1, 0, "R11");
    push(4'b0001, eff(GBC) + 1, 0, "R11");
    push(4'b0000, eff(GAB) + 1, 0, "R11");
    go = 1'b1; mark();
    step(N + 6);
    go = 1'b0;
    drain("R11");

    // request returns during turn-off
    push(4'b0001, N + 4, 0, "R3");
    push_on("R3");
    go = 1'b1; mark();
    drain("R3");
    push(4'b0111, N + 4, 0, "R10");
    push(4'b0011, eff(GCD) + 1, 0, "R10");
    push(4'b0001, eff(GBC) + 1, 0, "R10");
    push(4'b0000, eff(GAB) + 1, 0, "R10");
    push(4'b0001, N + 2, 0, "R10");
    push_on("R10");
    go = 1'b0; mark();
    step(N + 6);
    go = 1'b1;
    drain("R10");
    chk(state_o == 3'd3, "R10", "all-on after restart", int'(state_o), 3);

    // sparse ticks: one every third cycle
    tick_div = 3;
    push(4'b0111, 3 * N + 2, 2, "R12");
    push(4'b0011, 3 * eff(GCD) - 1, 2, "R12");
    push(4'b0001, 3 * eff(GBC) - 1, 2, "R12");
    push(4'b0000, 3 * eff(GAB) - 1, 2, "R12");
    go = 1'b0; mark();
    drain("R12");
    tick_div = 1;

    // start gate: request without compliance
    uv_ok = 1'b0; go = 1'b1;
    step(N + 20);
    chk(en_o == 4'b0000, "R1", "no start below lower limit", int'(en_o), 0);
    chk(state_o == 3'd0, "R1", "idle below lower limit", int'(state_o), 0);
    uv_ok = 1'b1; ov_hit = 1'b1;
    step(N + 20);
    chk(en_o == 4'b0000, "R1", "no start above upper limit", int'(en_o), 0);
    chk(state_o == 3'd0, "R1", "idle above upper limit", int'(state_o), 0);
    chk(q.size() == 0, "R1", "scoreboard empty", q.size(), 0);

    finish_run();
  end
endmodule